// File: doc/BRIEF.md
# Fill-Word Elastic Buffer

This block sits between the clock-recovery side and the retransmit side of a serial link retimer. Aligned 40-bit transmission words (four 10-bit characters) enter on the recovered clock with a valid strobe and a flag that marks idle fill words. They leave on the local reference clock, one word per read cycle. The two clocks may differ slightly in frequency. The rate difference is absorbed only at fill-word positions between frames. When the buffer runs too full, an incoming fill word is discarded. When it runs too empty, a fill word that has just been sent is sent once more. Data words are never created or removed.

Each side measures occupancy from its own pointer and the other side's pointer, which crosses over in Gray code through a two-stage synchronizer. After reset the read side sends fill words until occupancy first reaches the centre of the 16-word store. From then on it passes stored words.

Four sticky status bits (add, drop, underflow, overflow) can be read in the read domain and are cleared by a write-one-to-clear strobe. A one-cycle pulse marks each add event in the read domain and each drop event in the write domain.

Top module: `fillword_elastic_buf`

## Requirements
- R1: While reset is held, `out_fill` is 1, `out_word` equals the fill word, `status` is 0 and both event pulses are 0. After reset, the read side outputs only fill words until occupancy first reaches 8.
- R2: When no overflow occurs, every data word written leaves the read side exactly once, in the order it was written, and no other data word appears.
- R3: An incoming fill word is discarded (dropped) when write-side occupancy is 11 or more and the previous valid input word was a fill word that was stored. `drop_pulse` is high for the one write-clock cycle after the dropped word, and two drops never occur in back-to-back write cycles.
- R4: When read-side occupancy is 5 or less, the last output word is a fill word and that word was not itself an add, the read side repeats that word instead of reading the store (add). `add_pulse` is high in the same cycle as the repeated word.
- R5: A read slot in which the store is empty after the startup phase, and no add is taken, outputs the fill word with `out_fill` set and records an underflow.
- R6: A valid input word that is not dropped while the store holds 16 words is discarded and records an overflow. Stored words are never overwritten.
- R7: `status` bit 0 is add, bit 1 is drop, bit 2 is underflow and bit 3 is overflow. Each bit stays set until a 1 is written to the same bit of `st_clr`. A new event in the clearing cycle wins. The drop and overflow bits clear within a few read cycles, because the clear has to cross into the write domain.
- R8: `out_fill` marks output fill words. Every output fill word has the K28.5 comma (10'h0FA) as its first character, in bits 39:30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered (write) clock |
| wrst_n | input | 1 | Asynchronous active-low reset, write domain |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 40 | Aligned input transmission word |
| in_fill | input | 1 | Input word is an idle fill word |
| drop_pulse | output | 1 | One-cycle pulse per dropped fill word (write domain) |
| rclk | input | 1 | Local reference (read) clock |
| rrst_n | input | 1 | Asynchronous active-low reset, read domain |
| st_clr | input | 4 | Write-one-to-clear strobe for status bits |
| out_word | output | 40 | Output transmission word |
| out_fill | output | 1 | Output word is a fill word |
| add_pulse | output | 1 | One-cycle pulse per added fill word (read domain) |
| status | output | 4 | Sticky status: add, drop, underflow, overflow |

## Verification
The assertions check the following on every cycle:
- a drop pulse always follows a valid fill word, and drops never come in consecutive cycles;
- an add repeats an unchanged, non-added fill word;
- write-side occupancy never exceeds the store depth;
- output fill words carry the comma character;
- the sticky bits hold until they are cleared.

Some behaviour only the bench scenarios can show. These are the startup hold-off, lossless in-order delivery of data across clock-ratio changes, and that drops, adds, underflow and overflow actually happen when the read clock is slower, faster, starved or far slower. The bench also covers the delayed clearing of the write-domain bits.

// File: rtl/efb_pkg.sv
package efb_pkg;
  // comma character that opens every fill word
  localparam logic [9:0] K28_5 = 10'h0FA;

  // bit positions inside the status vector
  typedef enum int {
    ST_ADD   = 0,
    ST_DROP  = 1,
    ST_UNDER = 2,
    ST_OVER  = 3
  } st_bit_e;
endpackage

// File: rtl/efb_rst_sync.sv
module efb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage  <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      stage  <= 1'b1;
      srst_n <= stage;
    end
  end
endmodule

// File: rtl/efb_sync2.sv
module efb_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/efb_wr_ctl.sv
module efb_wr_ctl #(
  parameter int AW      = 4,
  parameter int WORD_W  = 40,
  parameter int HI_MARK = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_fill,
  input  logic [AW:0]       rgray_s,
  input  logic [1:0]        clr_tgl_s,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [WORD_W:0]   mem_wdata,
  output logic [AW:0]       wgray,
  output logic [AW:0]       occ,
  output logic              drop_pulse,
  output logic              st_drop,
  output logic              st_over
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] HI   = (AW+1)'(HI_MARK);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [AW:0] wbin, wbin_n, wgray_n, rbin_s;
  logic        kept_fill, kept_fill_n;
  logic        drop, wr, ovf;
  logic        st_drop_n, st_over_n;
  logic [1:0]  clr_seen, clr_ev;

  always_comb begin
    rbin_s = '0;
    for (int i = 0; i <= AW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign occ    = wbin - rbin_s;
  assign clr_ev = clr_tgl_s ^ clr_seen;

  always_comb begin
    drop    = in_valid & in_fill & kept_fill & (occ >= HI);
    wr      = in_valid & ~drop & (occ != FULL);
    ovf     = in_valid & ~drop & (occ == FULL);
    wbin_n  = wbin + {{AW{1'b0}}, wr};
    wgray_n = wbin_n ^ (wbin_n >> 1);
    kept_fill_n = kept_fill;
    if (wr)        kept_fill_n = in_fill;
    else if (drop) kept_fill_n = 1'b0;
    st_drop_n = drop | (st_drop & ~clr_ev[0]);
    st_over_n = ovf  | (st_over & ~clr_ev[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin       <= '0;
      wgray      <= '0;
      kept_fill  <= 1'b0;
      drop_pulse <= 1'b0;
      st_drop    <= 1'b0;
      st_over    <= 1'b0;
      clr_seen   <= '0;
    end else begin
      wbin       <= wbin_n;
      wgray      <= wgray_n;
      kept_fill  <= kept_fill_n;
      drop_pulse <= drop;
      st_drop    <= st_drop_n;
      st_over    <= st_over_n;
      clr_seen   <= clr_tgl_s;
    end
  end

  assign mem_we    = wr;
  assign mem_waddr = wbin[AW-1:0];
  assign mem_wdata = {in_fill, in_word};
endmodule

// File: rtl/efb_rd_ctl.sv
module efb_rd_ctl #(
  parameter int                AW        = 4,
  parameter int                WORD_W    = 40,
  parameter int                CENTRE    = 8,
  parameter int                LO_MARK   = 5,
  parameter logic [WORD_W-1:0] FILL_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW:0]       wgray_s,
  input  logic [WORD_W:0]   mem_rdata,
  input  logic [3:0]        st_clr,
  output logic [AW-1:0]     mem_raddr,
  output logic [WORD_W-1:0] out_word,
  output logic              out_fill,
  output logic              add_pulse,
  output logic              st_add,
  output logic              st_under,
  output logic [1:0]        clr_tgl
);
  import efb_pkg::*;
  localparam logic [AW:0] CEN = (AW+1)'(CENTRE);
  localparam logic [AW:0] LO  = (AW+1)'(LO_MARK);

  logic [AW:0]       rbin, rbin_n, wbin_s, occ;
  logic              primed, primed_n;
  logic              add, rd, udf;
  logic [WORD_W-1:0] out_word_n;
  logic              out_fill_n, st_add_n, st_under_n;
  logic [1:0]        clr_tgl_n;

  always_comb begin
    wbin_s = '0;
    for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign occ = wbin_s - rbin;

  always_comb begin
    primed_n = primed | (occ >= CEN);
    add      = primed & (occ <= LO) & out_fill & ~add_pulse;
    rd       = primed & ~add & (occ != '0);
    udf      = primed & ~add & (occ == '0);
    rbin_n   = rbin + {{AW{1'b0}}, rd};
    if (add) begin
      out_word_n = out_word;
      out_fill_n = out_fill;
    end else if (rd) begin
      out_word_n = mem_rdata[WORD_W-1:0];
      out_fill_n = mem_rdata[WORD_W];
    end else begin
      out_word_n = FILL_WORD;
      out_fill_n = 1'b1;
    end
    st_add_n   = add | (st_add & ~st_clr[ST_ADD]);
    st_under_n = udf | (st_under & ~st_clr[ST_UNDER]);
    clr_tgl_n  = clr_tgl ^ {st_clr[ST_OVER], st_clr[ST_DROP]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin      <= '0;
      primed    <= 1'b0;
      out_word  <= FILL_WORD;
      out_fill  <= 1'b1;
      add_pulse <= 1'b0;
      st_add    <= 1'b0;
      st_under  <= 1'b0;
      clr_tgl   <= '0;
    end else begin
      rbin      <= rbin_n;
      primed    <= primed_n;
      out_word  <= out_word_n;
      out_fill  <= out_fill_n;
      add_pulse <= add;
      st_add    <= st_add_n;
      st_under  <= st_under_n;
      clr_tgl   <= clr_tgl_n;
    end
  end

  assign mem_raddr = rbin[AW-1:0];
endmodule

// File: rtl/fillword_elastic_buf.sv
module fillword_elastic_buf #(
  parameter int                WORD_W    = 40,
  parameter int                CHAR_W    = 10,
  parameter int                AW        = 4,
  parameter int                SLACK     = 3,
  parameter logic [WORD_W-1:0] FILL_WORD = {10'h0FA, 10'h2AA, 10'h2AA, 10'h2AA}
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_fill,
  output logic              drop_pulse,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic [3:0]        st_clr,
  output logic [WORD_W-1:0] out_word,
  output logic              out_fill,
  output logic              add_pulse,
  output logic [3:0]        status
);
  localparam int DEPTH   = 1 << AW;
  localparam int CENTRE  = DEPTH / 2;
  localparam int HI_MARK = CENTRE + SLACK;
  localparam int LO_MARK = CENTRE - SLACK;

  logic              w_rst_n, r_rst_n;
  logic [WORD_W:0]   mem [DEPTH];
  logic              mem_we;
  logic [AW-1:0]     mem_waddr, mem_raddr;
  logic [WORD_W:0]   mem_wdata;
  logic [AW:0]       wgray, rgray, wgray_s, rgray_s, w_occ;
  logic [1:0]        clr_tgl, clr_tgl_s, wst_s;
  logic              st_drop, st_over, st_add, st_under;

  efb_rst_sync u_wrst (.clk(wclk), .arst_n(wrst_n), .srst_n(w_rst_n));
  efb_rst_sync u_rrst (.clk(rclk), .arst_n(rrst_n), .srst_n(r_rst_n));

  always_ff @(posedge wclk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
  end

  efb_wr_ctl #(.AW(AW), .WORD_W(WORD_W), .HI_MARK(HI_MARK)) u_wr (
    .clk(wclk), .rst_n(w_rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_fill(in_fill), .rgray_s(rgray_s), .clr_tgl_s(clr_tgl_s),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .wgray(wgray), .occ(w_occ), .drop_pulse(drop_pulse),
    .st_drop(st_drop), .st_over(st_over)
  );

  efb_rd_ctl #(.AW(AW), .WORD_W(WORD_W), .CENTRE(CENTRE), .LO_MARK(LO_MARK),
               .FILL_WORD(FILL_WORD)) u_rd (
    .clk(rclk), .rst_n(r_rst_n), .wgray_s(wgray_s), .mem_rdata(mem[mem_raddr]),
    .st_clr(st_clr), .mem_raddr(mem_raddr), .out_word(out_word),
    .out_fill(out_fill), .add_pulse(add_pulse), .st_add(st_add),
    .st_under(st_under), .clr_tgl(clr_tgl)
  );

  assign rgray = u_rd.rbin ^ (u_rd.rbin >> 1);

  efb_sync2 #(.W(AW+1)) u_s_w2r (.clk(rclk), .rst_n(r_rst_n), .d(wgray), .q(wgray_s));
  efb_sync2 #(.W(AW+1)) u_s_r2w (.clk(wclk), .rst_n(w_rst_n), .d(rgray), .q(rgray_s));
  efb_sync2 #(.W(2))    u_s_clr (.clk(wclk), .rst_n(w_rst_n), .d(clr_tgl), .q(clr_tgl_s));
  efb_sync2 #(.W(2))    u_s_wst (.clk(rclk), .rst_n(r_rst_n), .d({st_over, st_drop}), .q(wst_s));

  assign status = {wst_s[1], st_under, wst_s[0], st_add};
endmodule

// File: rtl/efb_chk.sv
module efb_chk #(
  parameter int WORD_W = 40,
  parameter int CHAR_W = 10,
  parameter int AW     = 4
) (
  input logic              wclk,
  input logic              rclk,
  input logic              wrs_n,
  input logic              rrs_n,
  input logic              in_valid,
  input logic              in_fill,
  input logic              drop_pulse,
  input logic              add_pulse,
  input logic              out_fill,
  input logic [WORD_W-1:0] out_word,
  input logic [3:0]        status,
  input logic [3:0]        st_clr,
  input logic [AW:0]       w_occ
);
  import efb_pkg::*;
  localparam logic [AW:0] DEPTH = (AW+1)'(1 << AW);

  a_r3_drop_on_fill: assert property (@(posedge wclk) disable iff (!wrs_n)
    drop_pulse |-> $past(in_valid && in_fill));

  a_r3_drop_spacing: assert property (@(posedge wclk) disable iff (!wrs_n)
    drop_pulse |=> !drop_pulse);

  a_r6_no_overrun: assert property (@(posedge wclk) disable iff (!wrs_n)
    w_occ <= DEPTH);

  a_r4_add_repeats_fill: assert property (@(posedge rclk) disable iff (!rrs_n)
    add_pulse |-> (out_fill && $past(out_fill) && !$past(add_pulse) && $stable(out_word)));

  a_r7_add_sets_status: assert property (@(posedge rclk) disable iff (!rrs_n)
    add_pulse |-> status[0]);

  a_r7_under_sticky: assert property (@(posedge rclk) disable iff (!rrs_n)
    ($past(status[2]) && !$past(st_clr[2])) |-> status[2]);

  a_r7_add_sticky: assert property (@(posedge rclk) disable iff (!rrs_n)
    ($past(status[0]) && !$past(st_clr[0])) |-> status[0]);

  a_r8_fill_comma: assert property (@(posedge rclk) disable iff (!rrs_n)
    out_fill |-> (out_word[WORD_W-1 -: CHAR_W] == CHAR_W'(K28_5)));
endmodule

bind fillword_elastic_buf efb_chk #(.WORD_W(WORD_W), .CHAR_W(CHAR_W), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .wrs_n(w_rst_n), .rrs_n(r_rst_n),
  .in_valid(in_valid), .in_fill(in_fill), .drop_pulse(drop_pulse),
  .add_pulse(add_pulse), .out_fill(out_fill), .out_word(out_word),
  .status(status), .st_clr(st_clr), .w_occ(w_occ)
);

// File: tb/sim_fillword_elastic_buf.sv
`timescale 1ns/1ps
module sim_fillword_elastic_buf;
  localparam logic [39:0] FILL = {10'h0FA, 10'h2AA, 10'h2AA, 10'h2AA};

  logic        wclk, rclk, wrst_n, rrst_n;
  logic        in_valid, in_fill, drop_pulse, out_fill, add_pulse;
  logic [39:0] in_word, out_word;
  logic [3:0]  st_clr, status;

  fillword_elastic_buf u0 (
    .wclk(wclk), .wrst_n(wrst_n), .in_valid(in_valid), .in_word(in_word),
    .in_fill(in_fill), .drop_pulse(drop_pulse), .rclk(rclk), .rrst_n(rrst_n),
    .st_clr(st_clr), .out_word(out_word), .out_fill(out_fill),
    .add_pulse(add_pulse), .status(status)
  );

  realtime rhalf = 2.0;
  initial wclk = 1'b0;
  always #2 wclk = ~wclk;
  initial begin
    rclk = 1'b0;
    #1;
    forever begin
      #(rhalf);
      rclk = ~rclk;
    end
  end

  int          compared = 0;
  int          mismatched = 0;
  int          written = 0;
  int          n_add = 0;
  int          n_drop = 0;
  logic [39:0] q[$];
  logic [31:0] seq = 0;
  bit          mon_en = 0;
  bit          allow_loss = 0;
  bit          done = 0;
  logic        prev_fill = 1'b1;
  logic        prev_add = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input int nd, input int nf);
    for (int d = 0; d < nd; d++) begin
      @(negedge wclk);
      in_valid = 1'b1; in_fill = 1'b0;
      in_word = {8'hA5, seq};
      seq++;
      q.push_back(in_word);
      written++;
    end
    for (int f = 0; f < nf; f++) begin
      @(negedge wclk);
      in_valid = 1'b1; in_fill = 1'b1; in_word = FILL;
      written++;
    end
  endtask

  task automatic idle(input int n);
    @(negedge wclk);
    in_valid = 1'b0; in_fill = 1'b0;
    repeat (n) @(negedge wclk);
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge rclk);
    st_clr = m;
    @(negedge rclk);
    st_clr = 4'h0;
    repeat (12) @(negedge rclk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // behavioural reference: ordered data queue, fill-word content, add rule
  always @(negedge rclk) begin
    if (mon_en) begin
      if (out_fill) begin
        chk(out_word == FILL, "R8 fill word content", out_word, FILL);
      end else begin
        chk(written >= 8, "R1 data before centre reached", written, 8);
        if (q.size() == 0) begin
          chk(1'b0, "R2 unexpected data word", out_word, 0);
        end else if (allow_loss) begin
          while (q.size() > 0 && q[0] != out_word) void'(q.pop_front());
          chk(q.size() > 0, "R6 data order with loss", out_word, 0);
          if (q.size() > 0) void'(q.pop_front());
        end else begin
          logic [39:0] e;
          e = q.pop_front();
          chk(out_word == e, "R2 data order", out_word, e);
        end
      end
      if (add_pulse) begin
        n_add++;
        chk(prev_fill && !prev_add && out_fill, "R4 add after plain fill",
            {prev_fill, prev_add, out_fill}, 3'b101);
      end
      prev_fill = out_fill;
      prev_add  = add_pulse;
    end
  end

  always @(negedge wclk) begin
    if (mon_en && drop_pulse) n_drop++;
  end

  initial begin
    #600000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    wrst_n = 1'b0; rrst_n = 1'b0;
    in_valid = 1'b0; in_fill = 1'b0; in_word = '0; st_clr = 4'h0;
    repeat (6) @(negedge wclk);
    // R1: reset state
    chk(out_fill == 1'b1, "R1 reset out_fill", out_fill, 1);
    chk(out_word == FILL, "R1 reset out_word", out_word, FILL);
    chk(status == 4'h0, "R1 reset status", status, 0);
    chk(add_pulse == 1'b0 && drop_pulse == 1'b0, "R1 reset pulses", {add_pulse, drop_pulse}, 0);
    wrst_n = 1'b1; rrst_n = 1'b1;
    repeat (4) @(negedge wclk);
    mon_en = 1'b1;

    // matched rates: startup, then clear and confirm quiet (R1, R2, R7)
    for (int i = 0; i < 40; i++) send(10, 6);
    clear(4'hF);
    for (int i = 0; i < 20; i++) send(10, 6);
    @(negedge rclk);
    chk(status == 4'h0, "R7 status cleared at matched rate", status, 0);

    // slower read clock: drops (R3)
    rhalf = 2.2;
    n_drop = 0;
    for (int i = 0; i < 60; i++) send(10, 6);
    @(negedge rclk);
    chk(n_drop > 0, "R3 drops seen", n_drop, 1);
    chk(status[1] == 1'b1, "R3 drop status", status, 4'h2);
    chk(status[3] == 1'b0, "R6 no overflow while dropping", status, 0);
    rhalf = 2.0;
    for (int i = 0; i < 10; i++) send(10, 6);
    @(negedge rclk);
    chk(status[1] == 1'b1, "R7 drop bit sticky", status, 4'h2);
    clear(4'hF);
    chk(status == 4'h0, "R7 clear after drops", status, 0);

    // faster read clock: adds (R4)
    rhalf = 1.85;
    n_add = 0;
    for (int i = 0; i < 60; i++) send(10, 6);
    @(negedge rclk);
    chk(n_add > 0, "R4 adds seen", n_add, 1);
    chk(status[0] == 1'b1, "R4 add status", status, 4'h1);
    chk(status[2] == 1'b0, "R5 no underflow while adding", status, 0);

    // starve the input: underflow (R5), all data delivered (R2)
    idle(200);
    @(negedge rclk);
    chk(status[2] == 1'b1, "R5 underflow status", status, 4'h4);
    chk(q.size() == 0, "R2 every data word delivered", q.size(), 0);

    // much slower read with back-to-back data: overflow (R6)
    clear(4'hF);
    rhalf = 4.0;
    allow_loss = 1'b1;
    send(80, 0);
    idle(4);
    repeat (6) @(negedge rclk);
    chk(status[3] == 1'b1, "R6 overflow status", status, 4'h8);
    rhalf = 2.0;
    send(0, 40);
    idle(100);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule